// File: doc/BRIEF.md
# Multiframe-Aligned Repeating Message Transmitter

This block holds a short unformatted data-link message and plays it out one bit at a time, whenever a downstream link bit tap asks for a bit. A processor loads between 1 and 64 bytes through a simple write port and then commits the message together with its length and its packing mode. Each byte carries either all eight of its bits or only its low six bits. The message then loops forever. Its first bit always goes out on the first bit request of a transmit multiframe, which a single-cycle pulse marks.

Storage is split into two banks. The processor always writes the bank that is not being transmitted. A commit arms a swap, and the swap happens at the first multiframe start after the running message has finished its last bit. Consecutive messages therefore join without a gap when each one fills whole multiframes. When a message ends before the next boundary, the block sends idle ones until that boundary. Whether the tap is serving a 24-frame or a 16-frame multiframe is set only by where the start pulses fall.

Top module: `rpt_msg_tx`

## Requirements
- R1: After reset `busy` and `bit_vld` are low. Until a message has been committed and started, every requested bit is 1, even when it is requested together with `mf_start`.
- R2: `bit_vld` is high in exactly the cycle after a cycle with `bit_req` high. `bit_out` in that cycle is the bit for that request.
- R3: With `cmt_short` = 0 at commit, each byte gives 8 bits, least significant bit first, starting at byte address 0 and going up through the addresses.
- R4: With `cmt_short` = 1 at commit, each byte gives only its bits 0 to 5, least significant first. Bits 6 and 7 are never sent.
- R5: A committed message begins only with a bit requested together with `mf_start`. Requests before that give 1.
- R6: After its last bit, the message sends 1 for every request until the next request that comes with `mf_start`, and then restarts from byte 0, bit 0.
- R7: An `mf_start` pulse that arrives while a message is in progress neither restarts nor interrupts it.
- R8: A valid commit raises `busy` on the next cycle. The new message replaces the old one only at the first `mf_start` after the old one has completed, and `busy` falls in that same step. Until then the old message keeps repeating.
- R9: Lengths 1 and 64 are both sent completely and repeat correctly.
- R10: A commit with a length of 0 or greater than 64 is ignored. `busy` stays low and the running message is unchanged.
- R11: Writes while a message is being sent go to the other bank and do not change the bits being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one byte into the idle bank |
| wr_addr | input | 6 | Byte address within the idle bank |
| wr_data | input | 8 | Byte to write |
| cmt_en | input | 1 | Commit the idle bank as the next message |
| cmt_len | input | 7 | Message length in bytes, 1 to 64 |
| cmt_short | input | 1 | 1: six bits per byte, 0: eight bits per byte |
| mf_start | input | 1 | Marks the first bit request of a transmit multiframe |
| bit_req | input | 1 | Request for one bit from the link tap |
| bit_out | output | 1 | Transmitted bit, valid with `bit_vld` |
| bit_vld | output | 1 | Response to the previous cycle's request |
| busy | output | 1 | A committed message is waiting for its swap |

## Verification
A wrong bit or byte pointer shows on `bit_out` at the very next request, because every request is compared with a model of the bank contents. A wrong bank select or a missed end-of-message shows at the first boundary after a commit. Old data keeps flowing, or a restart comes too early, and `busy` stays high or falls on a cycle without a boundary pulse. A miscounted packing width shows within one byte: a six-bit message then drifts against the expected order by its seventh bit.

// File: rtl/rpt_msg_pkg.sv
package rpt_msg_pkg;

   typedef enum logic {
      SQ_WAIT = 1'b0,
      SQ_SEND = 1'b1
   } sq_state_e;

   function automatic bit len_in_range(input int len, input int max_len);
      return (len >= 1) && (len <= max_len);
   endfunction

endpackage

// File: rtl/rpt_msg_store.sv
module rpt_msg_store #(
   parameter int NBANK  = 2,
   parameter int DEPTH  = 64,
   parameter int DW     = 8,
   parameter int AW     = 6,
   parameter int BANK_W = 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] wr_bank,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [BANK_W-1:0] rd_bank,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data
);

   logic [DW-1:0] bank_rd [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_en && (wr_bank == BANK_W'(b))) begin
            mem[wr_addr] <= wr_data;
         end
      end

      assign bank_rd[b] = mem[rd_addr];
   end

   always_comb begin
      rd_data = bank_rd[0];
      for (int b = 1; b < NBANK; b++) begin
         if (rd_bank == BANK_W'(b)) rd_data = bank_rd[b];
      end
   end

endmodule

// File: rtl/rpt_msg_bank_ctrl.sv
module rpt_msg_bank_ctrl import rpt_msg_pkg::*; #(
   parameter int MAX_BYTES = 64,
   parameter int LEN_W     = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmt_en,
   input  logic [LEN_W-1:0] cmt_len,
   input  logic             cmt_short,
   input  logic             swap,
   output logic             act_bank,
   output logic             act_valid,
   output logic             pending,
   output logic [LEN_W-1:0] act_len,
   output logic             act_short,
   output logic [LEN_W-1:0] idle_len,
   output logic             idle_short
);

   logic             cmt_ok;
   logic [LEN_W-1:0] len_q   [2];
   logic             short_q [2];

   assign cmt_ok = cmt_en && len_in_range(int'(cmt_len), MAX_BYTES);

   // per-bank configuration, written only while that bank is idle
   for (genvar b = 0; b < 2; b++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            len_q[b]   <= LEN_W'(1);
            short_q[b] <= 1'b0;
         end else if (cmt_ok && (act_bank != 1'(b))) begin
            len_q[b]   <= cmt_len;
            short_q[b] <= cmt_short;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_bank  <= 1'b0;
         act_valid <= 1'b0;
         pending   <= 1'b0;
      end else if (swap) begin
         act_bank  <= ~act_bank;
         act_valid <= 1'b1;
         pending   <= 1'b0;
      end else if (cmt_ok) begin
         pending   <= 1'b1;
      end
   end

   assign act_len    = len_q[act_bank];
   assign act_short  = short_q[act_bank];
   assign idle_len   = len_q[~act_bank];
   assign idle_short = short_q[~act_bank];

endmodule

// File: rtl/rpt_msg_seq.sv
module rpt_msg_seq import rpt_msg_pkg::*; #(
   parameter int BYTE_W  = 8,
   parameter int SHORT_W = 6,
   parameter int ADDR_W  = 6,
   parameter int LEN_W   = 7,
   parameter int BIT_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mf_start,
   input  logic              bit_req,
   input  logic              act_bank,
   input  logic              act_valid,
   input  logic              pending,
   input  logic [LEN_W-1:0]  act_len,
   input  logic              act_short,
   input  logic [LEN_W-1:0]  idle_len,
   input  logic              idle_short,
   output logic              rd_bank,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [BYTE_W-1:0] rd_data,
   output logic              swap,
   output logic              running,
   output logic              bit_out,
   output logic              bit_vld
);

   sq_state_e         state_q, state_d;
   logic [ADDR_W-1:0] byte_q, byte_d, cur_byte;
   logic [BIT_W-1:0]  bit_q, bit_d, cur_bit, top_bit;
   logic              at_rest, start, live, eff_short;
   logic [LEN_W-1:0]  eff_len;
   logic              last_bit, last_byte, tx_bit;

   assign at_rest   = (state_q == SQ_WAIT);
   assign start     = mf_start && at_rest && (act_valid || pending);
   assign swap      = start && pending;
   assign live      = (state_q == SQ_SEND) || start;
   assign eff_len   = swap ? idle_len   : act_len;
   assign eff_short = swap ? idle_short : act_short;
   assign cur_byte  = start ? '0 : byte_q;
   assign cur_bit   = start ? '0 : bit_q;
   assign rd_bank   = swap ? ~act_bank : act_bank;
   assign rd_addr   = cur_byte;

   // packing variant: a second, shorter byte width only when it differs
   if (SHORT_W == BYTE_W) begin : g_single_pack
      assign top_bit = BIT_W'(BYTE_W - 1);
   end else begin : g_dual_pack
      assign top_bit = eff_short ? BIT_W'(SHORT_W - 1) : BIT_W'(BYTE_W - 1);
   end

   assign last_bit  = (cur_bit == top_bit);
   assign last_byte = (LEN_W'(cur_byte) == (eff_len - LEN_W'(1)));
   assign tx_bit    = live ? rd_data[cur_bit] : 1'b1;

   always_comb begin
      state_d = state_q;
      byte_d  = byte_q;
      bit_d   = bit_q;
      if (start) begin
         state_d = SQ_SEND;
         byte_d  = '0;
         bit_d   = '0;
      end
      if (live && bit_req) begin
         if (last_bit) begin
            bit_d = '0;
            if (last_byte) begin
               byte_d  = '0;
               state_d = SQ_WAIT;
            end else begin
               byte_d = cur_byte + ADDR_W'(1);
            end
         end else begin
            bit_d = cur_bit + BIT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_WAIT;
         byte_q  <= '0;
         bit_q   <= '0;
         bit_out <= 1'b1;
         bit_vld <= 1'b0;
      end else begin
         state_q <= state_d;
         byte_q  <= byte_d;
         bit_q   <= bit_d;
         bit_vld <= bit_req;
         if (bit_req) bit_out <= tx_bit;
      end
   end

   assign running = (state_q == SQ_SEND);

endmodule

// File: rtl/rpt_msg_tx.sv
module rpt_msg_tx #(
   parameter int MAX_BYTES = 64,
   parameter int BYTE_W    = 8,
   parameter int SHORT_W   = 6,
   localparam int ADDR_W   = $clog2(MAX_BYTES),
   localparam int LEN_W    = $clog2(MAX_BYTES + 1),
   localparam int BIT_W    = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              cmt_en,
   input  logic [LEN_W-1:0]  cmt_len,
   input  logic              cmt_short,
   input  logic              mf_start,
   input  logic              bit_req,
   output logic              bit_out,
   output logic              bit_vld,
   output logic              busy
);

   if (MAX_BYTES < 2) begin : g_bad_depth
      $error("rpt_msg_tx: MAX_BYTES must be at least 2");
   end
   if (BYTE_W < 2) begin : g_bad_width
      $error("rpt_msg_tx: BYTE_W must be at least 2");
   end
   if ((SHORT_W < 1) || (SHORT_W > BYTE_W)) begin : g_bad_short
      $error("rpt_msg_tx: SHORT_W must lie in 1..BYTE_W");
   end

   logic              act_bank, act_valid, pending, swap, running;
   logic [LEN_W-1:0]  act_len, idle_len;
   logic              act_short, idle_short;
   logic              rd_bank;
   logic [ADDR_W-1:0] rd_addr;
   logic [BYTE_W-1:0] rd_data;

   rpt_msg_store #(
      .NBANK  (2),
      .DEPTH  (MAX_BYTES),
      .DW     (BYTE_W),
      .AW     (ADDR_W),
      .BANK_W (1)
   ) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (~act_bank),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_bank (rd_bank),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   rpt_msg_bank_ctrl #(
      .MAX_BYTES (MAX_BYTES),
      .LEN_W     (LEN_W)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmt_en     (cmt_en),
      .cmt_len    (cmt_len),
      .cmt_short  (cmt_short),
      .swap       (swap),
      .act_bank   (act_bank),
      .act_valid  (act_valid),
      .pending    (pending),
      .act_len    (act_len),
      .act_short  (act_short),
      .idle_len   (idle_len),
      .idle_short (idle_short)
   );

   rpt_msg_seq #(
      .BYTE_W  (BYTE_W),
      .SHORT_W (SHORT_W),
      .ADDR_W  (ADDR_W),
      .LEN_W   (LEN_W),
      .BIT_W   (BIT_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .mf_start   (mf_start),
      .bit_req    (bit_req),
      .act_bank   (act_bank),
      .act_valid  (act_valid),
      .pending    (pending),
      .act_len    (act_len),
      .act_short  (act_short),
      .idle_len   (idle_len),
      .idle_short (idle_short),
      .rd_bank    (rd_bank),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .swap       (swap),
      .running    (running),
      .bit_out    (bit_out),
      .bit_vld    (bit_vld)
   );

   assign busy = pending;

endmodule

// File: rtl/rpt_msg_tx_chk.sv
module rpt_msg_tx_chk #(
   parameter int MAX_BYTES = 64,
   parameter int LEN_W     = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_req,
   input logic             mf_start,
   input logic             cmt_en,
   input logic [LEN_W-1:0] cmt_len,
   input logic             bit_out,
   input logic             bit_vld,
   input logic             busy,
   input logic             act_bank,
   input logic             act_valid,
   input logic             running
);

   logic len_good;
   assign len_good = (cmt_len != '0) && (cmt_len <= LEN_W'(MAX_BYTES));

   AST_VLD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bit_req |=> bit_vld);  // R2
   AST_NO_VLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_req |=> !bit_vld);  // R2
   AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_req && !running && !mf_start) |=> bit_out);  // R5
   AST_RUN_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> act_valid);  // R5
   AST_START_ON_MF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(mf_start));  // R5
   AST_BUSY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_en && len_good && !(mf_start && !running && busy)) |=> busy);  // R8
   AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !mf_start |=> $stable(act_bank));  // R8
   AST_BUSY_DROP_AT_MF: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mf_start));  // R8
   AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_en && !len_good && !busy) |=> !busy);  // R10

endmodule

bind rpt_msg_tx rpt_msg_tx_chk #(
   .MAX_BYTES (MAX_BYTES),
   .LEN_W     (LEN_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bit_req   (bit_req),
   .mf_start  (mf_start),
   .cmt_en    (cmt_en),
   .cmt_len   (cmt_len),
   .bit_out   (bit_out),
   .bit_vld   (bit_vld),
   .busy      (busy),
   .act_bank  (act_bank),
   .act_valid (act_valid),
   .running   (running)
);

// File: tb/tb_rpt_msg_tx.sv
`timescale 1ns/1ps
module tb_rpt_msg_tx;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [5:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       cmt_en = 1'b0;
   logic [6:0] cmt_len = '0;
   logic       cmt_short = 1'b0;
   logic       mf_start = 1'b0;
   logic       bit_req = 1'b0;
   logic       bit_out, bit_vld, busy;

   int n_total = 0;
   int n_pass  = 0;
   bit done    = 1'b0;

   logic [7:0] cur_msg [64];
   logic [7:0] nxt_msg [64];
   int         cur_len = 0, nxt_len = 0;
   bit         cur_short = 1'b0, nxt_short = 1'b0, nxt_pend = 1'b0;

   always #2 clk = ~clk;

   rpt_msg_tx dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .cmt_en    (cmt_en),
      .cmt_len   (cmt_len),
      .cmt_short (cmt_short),
      .mf_start  (mf_start),
      .bit_req   (bit_req),
      .bit_out   (bit_out),
      .bit_vld   (bit_vld),
      .busy      (busy)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input int act, input int exp);
      n_total++;
      if (ok) n_pass++;
      else $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_pass, n_total);
   endtask

   task automatic write_byte(input int a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic commit(input int len, input bit sh);
      cmt_en = 1'b1; cmt_len = 7'(len); cmt_short = sh;
      @(negedge clk);
      cmt_en = 1'b0;
   endtask

   // fill the idle bank and commit; reference kept as the next message
   task automatic load_msg(input int len, input bit sh, input int mul, input int add);
      for (int i = 0; i < len; i++) begin
         nxt_msg[i] = 8'((i * mul + add) & 8'hFF);
         write_byte(i, nxt_msg[i]);
      end
      nxt_len = len; nxt_short = sh; nxt_pend = 1'b1;
      commit(len, sh);
   endtask

   task automatic req_bit(input bit mf, output bit b, output bit v);
      bit_req = 1'b1; mf_start = mf;
      @(negedge clk);
      bit_req = 1'b0; mf_start = 1'b0;
      b = bit_out; v = bit_vld;
   endtask

   task automatic adopt();
      if (nxt_pend) begin
         for (int i = 0; i < 64; i++) cur_msg[i] = nxt_msg[i];
         cur_len = nxt_len; cur_short = nxt_short; nxt_pend = 1'b0;
      end
   endtask

   task automatic check_stream(input int first, input int count, input bit mf_first,
                               input int mf_mid, input string rq);
      bit b, v;
      if (mf_first) adopt();
      for (int k = 0; k < count; k++) begin
         int per, idx;
         bit e;
         per = cur_short ? 6 : 8;
         idx = first + k;
         e = cur_msg[idx / per][idx % per];
         req_bit((k == 0 && mf_first) || (k == mf_mid), b, v);
         check(b == e && v, rq, $sformatf("bit %0d", idx), int'(b), int'(e));
      end
   endtask

   task automatic check_idle(input int count, input string rq);
      bit b, v;
      for (int k = 0; k < count; k++) begin
         req_bit(1'b0, b, v);
         check(b == 1'b1 && v, rq, "idle bit", int'(b), 1);
      end
   endtask

   task automatic t_reset();
      bit b, v;
      check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
      check(bit_vld == 1'b0, "R1", "bit_vld after reset", int'(bit_vld), 0);
      req_bit(1'b0, b, v);
      check(b == 1'b1, "R1", "bit with no message", int'(b), 1);
      check(v == 1'b1, "R2", "vld after request", int'(v), 1);
      @(negedge clk);
      check(bit_vld == 1'b0, "R2", "vld without request", int'(bit_vld), 0);
      req_bit(1'b1, b, v);
      check(b == 1'b1, "R1", "boundary with no message", int'(b), 1);
   endtask

   task automatic t_eight_bit();
      load_msg(2, 1'b0, 8'h97, 8'hA5);   // A5, 3C
      check(busy == 1'b1, "R8", "busy after commit", int'(busy), 1);
      check_idle(3, "R5");
      check_stream(0, 16, 1'b1, -1, "R3");
      check(busy == 1'b0, "R8", "busy after swap", int'(busy), 0);
      check_idle(4, "R6");
      check_stream(0, 16, 1'b1, -1, "R6");
   endtask

   task automatic t_six_bit();
      load_msg(3, 1'b1, 8'h63, 8'hC7);
      check(busy == 1'b1, "R8", "busy six-bit commit", int'(busy), 1);
      check_stream(0, 18, 1'b1, -1, "R4");
      check(busy == 1'b0, "R8", "busy after six-bit swap", int'(busy), 0);
      check_idle(2, "R6");
   endtask

   task automatic t_swap_mid();
      check_stream(0, 5, 1'b1, -1, "R4");
      load_msg(2, 1'b0, 8'h87, 8'h5A);
      check(busy == 1'b1, "R8", "busy while old runs", int'(busy), 1);
      check_stream(5, 13, 1'b0, -1, "R11");
      check(busy == 1'b1, "R8", "busy before boundary", int'(busy), 1);
      check_idle(2, "R8");
      check_stream(0, 16, 1'b1, 6, "R7");
      check(busy == 1'b0, "R8", "busy after late swap", int'(busy), 0);
   endtask

   task automatic t_len_one();
      load_msg(1, 1'b0, 0, 8'h81);
      check_stream(0, 8, 1'b1, -1, "R9");
      check_idle(1, "R9");
      check_stream(0, 8, 1'b1, -1, "R9");
   endtask

   task automatic t_bad_len();
      write_byte(0, 8'h00);
      commit(0, 1'b0);
      check(busy == 1'b0, "R10", "busy after length 0", int'(busy), 0);
      commit(65, 1'b0);
      check(busy == 1'b0, "R10", "busy after length 65", int'(busy), 0);
      check_stream(0, 8, 1'b1, -1, "R10");
   endtask

   task automatic t_len_max();
      load_msg(64, 1'b0, 37, 5);
      check_stream(0, 512, 1'b1, 192, "R9");
      check_idle(1, "R6");
      check_stream(0, 8, 1'b1, -1, "R9");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_eight_bit();
      t_six_bit();
      t_swap_mid();
      t_len_one();
      t_bad_len();
      t_len_max();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_total++;
         $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule